// File: doc/BRIEF.md
# Path-Associative Trace Cache

This block holds recently built dynamic instruction traces so that a wide fetch stage can supply a whole trace in one access. A trace is named by the address of its first instruction together with the ordered taken/not-taken results of the conditional branches inside it. Several traces that start at the same address but take different paths through later branches can be resident together, each in its own way of the set that the start address selects.

The fetch side presents a start address and a vector of predicted branch results. One cycle later the block answers with a hit flag, the trace's instruction count, its branch count and up to sixteen instruction words, or a miss with all data fields at zero. A trace builder writes finished traces through a fill port. A fill whose name matches a resident trace rewrites that way. Otherwise the fill takes the lowest invalid way of the set, or the least recently used way when the set is full. Every lookup hit refreshes the recency of the way it read.

The storage is a register array of 8 sets by 4 ways, with up to 16 words of 32 bits per trace. All sizes are parameters.

Top module: `trace_cache`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `rsp_valid` and `rsp_hit` are 0. Every entry is invalid after reset, so a lookup before any fill misses.
- R2: `rsp_valid` is 1 in exactly the cycle that follows a cycle with `lk_req` high, and 0 after a cycle without it.
- R3: A lookup hits a way when that way is valid, its stored start address equals `lk_pc` in all bits, and bits 0 to n-1 of `lk_path` equal the stored outcomes, where n is the stored branch count (bit 0 is the first branch, 1 means taken). Bits n and above of `lk_path` are ignored. On a hit the stored words, instruction count and branch count are returned.
- R4: Traces with the same start address and different outcome bits live in different ways of one set at the same time, and each can be hit.
- R5: A fill whose start address, branch count and first branch-count outcome bits all equal those of a valid way in its set overwrites that way. No other way is disturbed. Outcome bits of `fl_path` at and above `fl_nbr` are ignored.
- R6: A fill that matches no resident trace goes to the lowest-numbered invalid way of its set. If all ways are valid, it replaces the least recently used way.
- R7: A lookup hit makes the way it hit the most recently used way of its set in the same cycle. A fill makes its way the most recently used way.
- R8: On a miss, `rsp_hit`, `rsp_ninsn`, `rsp_nbr` and `rsp_words` are all 0.
- R9: When several ways of a set match one lookup, the lowest-numbered way is returned.
- R10: A lookup and a fill in the same cycle see the array as it was before that fill.
- R11: The set index is `pc[4:2]` for the default 8 sets, and the word offset bits [1:0] are not part of it. Traces in different sets do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_req | input | 1 | Lookup request |
| lk_pc | input | 32 | Lookup start address |
| lk_path | input | 15 | Predicted branch outcomes, bit 0 = first branch |
| fl_req | input | 1 | Fill request |
| fl_pc | input | 32 | Start address of the trace being filled |
| fl_nbr | input | 4 | Number of conditional branches in the filled trace (0 to 15) |
| fl_path | input | 15 | Outcomes of the filled trace's branches, bit 0 = first |
| fl_ninsn | input | 5 | Instruction count of the filled trace (1 to 16) |
| fl_words | input | 512 | Instruction words, word k in bits [32k+31:32k] |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_nbr | output | 4 | Branch count of the hit trace |
| rsp_ninsn | output | 5 | Instruction count of the hit trace |
| rsp_words | output | 512 | Instruction words of the hit trace |

## Verification
The main function is tested with four traces that all start at one address. Their branch counts are 0, 1 and 2 and their outcome patterns overlap. Lookups are made with outcome vectors that match one, several or none of these traces, and with garbage in the high bits. This separates the prefix-match rule from a full-vector compare, and lowest-way priority from any other choice. A sequence of hits followed by an allocating fill shows whether recency follows lookups as well as fills. A refill of an existing name, once with clean high bits and once with garbage in them, is followed by a lookup of the trace that an eviction would have removed. This tells an in-place rewrite apart from a fresh allocation. Separate tests cover misses from another set and from another tag in the same set, a fill and a lookup in the same cycle, and the effect of reset.

// File: rtl/tc_pkg.sv
package tc_pkg;

  // Byte offset bits of a 32-bit instruction word below the set index.
  localparam int TC_WORD_OFS = 2;

  // Mask with the low n bits set: selects the outcome bits that belong to a
  // trace holding n conditional branches.
  function automatic logic [31:0] tc_prefix_mask(input int n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/tc_way_cmp.sv
module tc_way_cmp #(
  parameter int PC_W   = 32,
  parameter int PATH_W = 15,
  parameter int NBR_W  = 4
) (
  input  logic              ent_v,
  input  logic [PC_W-1:0]   ent_pc,
  input  logic [PATH_W-1:0] ent_path,
  input  logic [NBR_W-1:0]  ent_nbr,
  input  logic [PC_W-1:0]   key_pc,
  input  logic [PATH_W-1:0] key_path,
  input  logic [NBR_W-1:0]  key_nbr,
  input  logic              exact,
  output logic              match
);
  import tc_pkg::*;

  logic [PATH_W-1:0] sel;
  logic              path_eq;
  logic              nbr_eq;

  always_comb begin
    sel     = PATH_W'(tc_prefix_mask(int'(ent_nbr)));
    path_eq = ((key_path ^ ent_path) & sel) == '0;
    nbr_eq  = !exact || (key_nbr == ent_nbr);
    match   = ent_v && (key_pc == ent_pc) && path_eq && nbr_eq;
  end

endmodule

// File: rtl/tc_lru.sv
module tc_lru #(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_en,
  input  logic [IDX_W-1:0] a_set,
  input  logic [WAY_W-1:0] a_way,
  input  logic             b_en,
  input  logic [IDX_W-1:0] b_set,
  input  logic [WAY_W-1:0] b_way,
  input  logic [IDX_W-1:0] q_set,
  input  logic [WAYS-1:0]  q_valid,
  output logic [WAY_W-1:0] victim
);

  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  // Age 0 is the most recent way and WAYS-1 the least recent. The ages of one
  // set are always a permutation of 0..WAYS-1.
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] age_a [SETS][WAYS];
  logic [WAY_W-1:0] age_n [SETS][WAYS];

  // Lookup touch first, fill touch applied on top of it.
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        age_a[s][w] = age_q[s][w];
        if (a_en && a_set == IDX_W'(s)) begin
          if (a_way == WAY_W'(w)) age_a[s][w] = '0;
          else if (age_q[s][w] < age_q[s][a_way]) age_a[s][w] = age_q[s][w] + 1'b1;
        end
      end
    end
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        age_n[s][w] = age_a[s][w];
        if (b_en && b_set == IDX_W'(s)) begin
          if (b_way == WAY_W'(w)) age_n[s][w] = '0;
          else if (age_a[s][w] < age_a[s][b_way]) age_n[s][w] = age_a[s][w] + 1'b1;
        end
      end
    end
  end

  // Victim: lowest invalid way, else the oldest way after this cycle's lookup.
  logic got_free;
  always_comb begin
    victim   = '0;
    got_free = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!got_free && !q_valid[w]) begin
        victim   = WAY_W'(w);
        got_free = 1'b1;
      end
    end
    if (!got_free) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_a[q_set][w] == OLDEST) victim = WAY_W'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else begin
      age_q <= age_n;
    end
  end

  // Checker state
  logic [WAYS-1:0]  old_vec;
  logic             chk_arm_q;
  logic [IDX_W-1:0] chk_set_q;
  logic [WAY_W-1:0] chk_way_q;

  always_comb begin
    for (int w = 0; w < WAYS; w++) old_vec[w] = (age_q[q_set][w] == OLDEST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_arm_q <= 1'b0;
      chk_set_q <= '0;
      chk_way_q <= '0;
    end else begin
      chk_arm_q <= a_en && !(b_en && b_set == a_set);
      chk_set_q <= a_set;
      chk_way_q <= a_way;
    end
  end

  // R6
  lru_single_oldest_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(old_vec) == 1);

  // R7
  lru_hit_refresh_chk: assert property (@(posedge clk) disable iff (rst)
    chk_arm_q |-> age_q[chk_set_q][chk_way_q] == '0);

endmodule

// File: rtl/trace_cache.sv
module trace_cache #(
  parameter int PC_W     = 32,
  parameter int INSN_W   = 32,
  parameter int SETS     = 8,
  parameter int WAYS     = 4,
  parameter int MAX_INSN = 16,
  localparam int PATH_W = MAX_INSN - 1,
  localparam int NBR_W  = $clog2(MAX_INSN),
  localparam int CNT_W  = $clog2(MAX_INSN + 1),
  localparam int LINE_W = MAX_INSN * INSN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_req,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [PATH_W-1:0] lk_path,
  input  logic              fl_req,
  input  logic [PC_W-1:0]   fl_pc,
  input  logic [NBR_W-1:0]  fl_nbr,
  input  logic [PATH_W-1:0] fl_path,
  input  logic [CNT_W-1:0]  fl_ninsn,
  input  logic [LINE_W-1:0] fl_words,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [NBR_W-1:0]  rsp_nbr,
  output logic [CNT_W-1:0]  rsp_ninsn,
  output logic [LINE_W-1:0] rsp_words
);
  import tc_pkg::*;

  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int OFS   = TC_WORD_OFS;

  // Entry storage
  logic              v_q    [SETS][WAYS];
  logic [PC_W-1:0]   pc_q   [SETS][WAYS];
  logic [PATH_W-1:0] path_q [SETS][WAYS];
  logic [NBR_W-1:0]  nbr_q  [SETS][WAYS];
  logic [CNT_W-1:0]  cnt_q  [SETS][WAYS];
  logic [LINE_W-1:0] line_q [SETS][WAYS];

  logic [IDX_W-1:0]  lk_idx, fl_idx;
  logic [WAYS-1:0]   lk_hitv, fl_hitv, fl_vvec;
  logic              lk_any, fl_any;
  logic [WAY_W-1:0]  lk_way, fl_mway, fl_way, victim;
  logic [PATH_W-1:0] fl_path_m;

  assign lk_idx    = lk_pc[OFS +: IDX_W];
  assign fl_idx    = fl_pc[OFS +: IDX_W];
  assign fl_path_m = fl_path & PATH_W'(tc_prefix_mask(int'(fl_nbr)));

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign fl_vvec[w] = v_q[fl_idx][w];

    tc_way_cmp #(.PC_W(PC_W), .PATH_W(PATH_W), .NBR_W(NBR_W)) u_lk_cmp (
      .ent_v   (v_q[lk_idx][w]),
      .ent_pc  (pc_q[lk_idx][w]),
      .ent_path(path_q[lk_idx][w]),
      .ent_nbr (nbr_q[lk_idx][w]),
      .key_pc  (lk_pc),
      .key_path(lk_path),
      .key_nbr ('0),
      .exact   (1'b0),
      .match   (lk_hitv[w])
    );

    tc_way_cmp #(.PC_W(PC_W), .PATH_W(PATH_W), .NBR_W(NBR_W)) u_fl_cmp (
      .ent_v   (v_q[fl_idx][w]),
      .ent_pc  (pc_q[fl_idx][w]),
      .ent_path(path_q[fl_idx][w]),
      .ent_nbr (nbr_q[fl_idx][w]),
      .key_pc  (fl_pc),
      .key_path(fl_path_m),
      .key_nbr (fl_nbr),
      .exact   (1'b1),
      .match   (fl_hitv[w])
    );
  end

  // Lowest matching way wins.
  always_comb begin
    lk_any  = 1'b0;
    lk_way  = '0;
    fl_any  = 1'b0;
    fl_mway = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (lk_hitv[w]) begin
        lk_any = 1'b1;
        lk_way = WAY_W'(w);
      end
      if (fl_hitv[w]) begin
        fl_any  = 1'b1;
        fl_mway = WAY_W'(w);
      end
    end
  end

  assign fl_way = fl_any ? fl_mway : victim;

  tc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk    (clk),
    .rst    (rst),
    .a_en   (lk_req && lk_any),
    .a_set  (lk_idx),
    .a_way  (lk_way),
    .b_en   (fl_req),
    .b_set  (fl_idx),
    .b_way  (fl_way),
    .q_set  (fl_idx),
    .q_valid(fl_vvec),
    .victim (victim)
  );

  // Valid bits carry reset; payload fields are plain write-only storage.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          v_q[s][w] <= 1'b0;
    end else if (fl_req) begin
      v_q[fl_idx][fl_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fl_req) begin
      pc_q[fl_idx][fl_way]   <= fl_pc;
      path_q[fl_idx][fl_way] <= fl_path_m;
      nbr_q[fl_idx][fl_way]  <= fl_nbr;
      cnt_q[fl_idx][fl_way]  <= fl_ninsn;
      line_q[fl_idx][fl_way] <= fl_words;
    end
  end

  // Registered response, read from the array before this cycle's fill.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_nbr   <= '0;
      rsp_ninsn <= '0;
      rsp_words <= '0;
    end else begin
      rsp_valid <= lk_req;
      rsp_hit   <= lk_req && lk_any;
      if (lk_req && lk_any) begin
        rsp_nbr   <= nbr_q[lk_idx][lk_way];
        rsp_ninsn <= cnt_q[lk_idx][lk_way];
        rsp_words <= line_q[lk_idx][lk_way];
      end else begin
        rsp_nbr   <= '0;
        rsp_ninsn <= '0;
        rsp_words <= '0;
      end
    end
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> rsp_valid);

  // R2
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !rsp_valid);

  // R5
  fill_unique_name_chk: assert property (@(posedge clk) disable iff (rst)
    fl_req |-> $onehot0(fl_hitv));

  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_words == '0 && rsp_ninsn == '0 && rsp_nbr == '0));

endmodule

// File: tb/trace_cache_tb.sv
module trace_cache_tb_top;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         lk_req;
  logic [31:0]  lk_pc;
  logic [14:0]  lk_path;
  logic         fl_req;
  logic [31:0]  fl_pc;
  logic [3:0]   fl_nbr;
  logic [14:0]  fl_path;
  logic [4:0]   fl_ninsn;
  logic [511:0] fl_words;
  logic         rsp_valid, rsp_hit;
  logic [3:0]   rsp_nbr;
  logic [4:0]   rsp_ninsn;
  logic [511:0] rsp_words;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  trace_cache dut_i (
    .clk(clk), .rst(rst),
    .lk_req(lk_req), .lk_pc(lk_pc), .lk_path(lk_path),
    .fl_req(fl_req), .fl_pc(fl_pc), .fl_nbr(fl_nbr), .fl_path(fl_path),
    .fl_ninsn(fl_ninsn), .fl_words(fl_words),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_nbr(rsp_nbr),
    .rsp_ninsn(rsp_ninsn), .rsp_words(rsp_words)
  );

  function automatic logic [511:0] wgen(input logic [7:0] seed);
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[k*32 +: 32] = {8'hA5, seed, 8'(k), 8'h3C};
    return v;
  endfunction

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_fill(input logic [31:0] pc, input logic [3:0] nbr, input logic [14:0] path,
                         input logic [4:0] n, input logic [7:0] seed);
    @(negedge clk);
    fl_req = 1'b1; fl_pc = pc; fl_nbr = nbr; fl_path = path; fl_ninsn = n; fl_words = wgen(seed);
    @(negedge clk);
    fl_req = 1'b0;
  endtask

  // Drive one lookup; on return the registered response is stable.
  task automatic do_look(input logic [31:0] pc, input logic [14:0] path);
    @(negedge clk);
    lk_req = 1'b1; lk_pc = pc; lk_path = path;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  typedef struct packed {
    logic        look;
    logic [31:0] pc;
    logic [3:0]  nbr;
    logic [14:0] path;
    logic [4:0]  ninsn;
    logic [7:0]  seed;
    logic        ehit;
    logic [4:0]  ecnt;
    logic [7:0]  eseed;
  } row_t;

  localparam int NROW = 21;
  localparam row_t TBL [NROW] = '{
    '{1'b0, 32'h1000, 4'd2, 15'h0001, 5'd5,  8'd1, 1'b0, 5'd0,  8'd0}, // fill way0
    '{1'b0, 32'h1000, 4'd2, 15'h0002, 5'd16, 8'd2, 1'b0, 5'd0,  8'd0}, // fill way1
    '{1'b0, 32'h1000, 4'd1, 15'h0001, 5'd3,  8'd3, 1'b0, 5'd0,  8'd0}, // fill way2
    '{1'b0, 32'h1000, 4'd0, 15'h0000, 5'd1,  8'd4, 1'b0, 5'd0,  8'd0}, // fill way3
    '{1'b1, 32'h1000, 4'd0, 15'h0001, 5'd0,  8'd0, 1'b1, 5'd5,  8'd1}, // R9 way0 over way2
    '{1'b1, 32'h1000, 4'd0, 15'h7FF1, 5'd0,  8'd0, 1'b1, 5'd5,  8'd1}, // R3 high bits ignored
    '{1'b1, 32'h1000, 4'd0, 15'h0002, 5'd0,  8'd0, 1'b1, 5'd16, 8'd2}, // R9 way1 over way3
    '{1'b1, 32'h1000, 4'd0, 15'h0003, 5'd0,  8'd0, 1'b1, 5'd3,  8'd3}, // R3 one-branch prefix
    '{1'b1, 32'h1000, 4'd0, 15'h0000, 5'd0,  8'd0, 1'b1, 5'd1,  8'd4}, // R4 four paths resident
    '{1'b1, 32'h1004, 4'd0, 15'h0001, 5'd0,  8'd0, 1'b0, 5'd0,  8'd0}, // R11 other set
    '{1'b1, 32'h1020, 4'd0, 15'h0001, 5'd0,  8'd0, 1'b0, 5'd0,  8'd0}, // R8 same set, other tag
    '{1'b1, 32'h1000, 4'd0, 15'h0001, 5'd0,  8'd0, 1'b1, 5'd5,  8'd1}, // R7 refresh way0
    '{1'b0, 32'h1000, 4'd3, 15'h0007, 5'd7,  8'd5, 1'b0, 5'd0,  8'd0}, // R6 evicts way1
    '{1'b1, 32'h1000, 4'd0, 15'h0002, 5'd0,  8'd0, 1'b1, 5'd1,  8'd4}, // R6 old way1 gone
    '{1'b1, 32'h1000, 4'd0, 15'h0007, 5'd0,  8'd0, 1'b1, 5'd7,  8'd5}, // R6 new trace
    '{1'b0, 32'h1000, 4'd2, 15'h0001, 5'd9,  8'd6, 1'b0, 5'd0,  8'd0}, // R5 rewrite way0
    '{1'b1, 32'h1000, 4'd0, 15'h0001, 5'd0,  8'd0, 1'b1, 5'd9,  8'd6}, // R5 new content
    '{1'b1, 32'h1000, 4'd0, 15'h0003, 5'd0,  8'd0, 1'b1, 5'd3,  8'd3}, // R5 way2 kept
    '{1'b0, 32'h1000, 4'd2, 15'h7FF9, 5'd2,  8'd7, 1'b0, 5'd0,  8'd0}, // R5 rewrite, junk high bits
    '{1'b1, 32'h1000, 4'd0, 15'h0001, 5'd0,  8'd0, 1'b1, 5'd2,  8'd7}, // R5 new content
    '{1'b1, 32'h1000, 4'd0, 15'h0000, 5'd0,  8'd0, 1'b1, 5'd1,  8'd4}  // R5 LRU way3 kept
  };

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; lk_req = 1'b0; lk_pc = '0; lk_path = '0;
    fl_req = 1'b0; fl_pc = '0; fl_nbr = '0; fl_path = '0; fl_ninsn = '0; fl_words = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 512'(rsp_valid), 512'(0));
    rst = 1'b0;
    @(negedge clk);
    chk("R1 hit after reset", 512'(rsp_hit), 512'(0));
    chk("R1 valid after reset", 512'(rsp_valid), 512'(0));
    do_look(32'h1000, 15'h0);
    chk("R1 empty lookup misses", 512'(rsp_hit), 512'(0));
    chk("R2 valid after request", 512'(rsp_valid), 512'(1));
    @(negedge clk);
    chk("R2 valid drops", 512'(rsp_valid), 512'(0));

    for (int i = 0; i < NROW; i++) begin
      if (!TBL[i].look) begin
        do_fill(TBL[i].pc, TBL[i].nbr, TBL[i].path, TBL[i].ninsn, TBL[i].seed);
      end else begin
        do_look(TBL[i].pc, TBL[i].path);
        chk($sformatf("row %0d R2 valid", i), 512'(rsp_valid), 512'(1));
        chk($sformatf("row %0d R3 hit", i), 512'(rsp_hit), 512'(TBL[i].ehit));
        chk($sformatf("row %0d R3 ninsn", i), 512'(rsp_ninsn), 512'(TBL[i].ecnt));
        chk($sformatf("row %0d R8 words", i), rsp_words,
            TBL[i].ehit ? wgen(TBL[i].eseed) : 512'(0));
      end
    end

    // R3 branch count returned
    do_look(32'h1000, 15'h0007);
    chk("R3 nbr out", 512'(rsp_nbr), 512'(3));
    chk("R3 words", rsp_words, wgen(8'd5));

    // R10 fill and lookup in one cycle, new set 2
    @(negedge clk);
    fl_req = 1'b1; fl_pc = 32'h2008; fl_nbr = 4'd1; fl_path = 15'h0; fl_ninsn = 5'd4; fl_words = wgen(8'd8);
    lk_req = 1'b1; lk_pc = 32'h2008; lk_path = 15'h0;
    @(negedge clk);
    fl_req = 1'b0; lk_req = 1'b0;
    chk("R10 same-cycle lookup misses", 512'(rsp_hit), 512'(0));
    do_look(32'h2008, 15'h0);
    chk("R10 later lookup hits", 512'(rsp_hit), 512'(1));
    chk("R10 ninsn", 512'(rsp_ninsn), 512'(4));
    do_look(32'h2008, 15'h0001);
    chk("R3 outcome mismatch misses", 512'(rsp_hit), 512'(0));
    chk("R8 nbr zero on miss", 512'(rsp_nbr), 512'(0));

    // R11 set-0 contents untouched by set-2 traffic
    do_look(32'h1000, 15'h0001);
    chk("R11 set0 intact", 512'(rsp_ninsn), 512'(2));

    // R1 reset clears everything
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    do_look(32'h1000, 15'h0001);
    chk("R1 miss after reset", 512'(rsp_hit), 512'(0));
    chk("R1 words after reset", rsp_words, 512'(0));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule